// File: doc/BRIEF.md
# Frame Sync Loss Monitor

This block watches the frame-sync line of a serial audio link once per bit clock and decides whether the link is in step. A good frame has the sync line high for exactly 16 bit clocks and then low for exactly 240. When a run of either level has the wrong length, the block raises a loss flag at once. It clears that flag only after it has seen one complete, correct high/low frame again. After reset the block starts out unlocked.

The same block also conditions the PCM sample stream headed for the converter. A small write port loads a control word and a pin-status word. The control word decides three things: whether loss of sync forces the outgoing samples to zero, whether each sample is negated on its way through, and whether the general-purpose output pin follows a bit from outgoing link slot 12 or a register bit. Samples are 20-bit two's complement. Each sample carries a valid strobe on both input and output, and the output lags the input by one clock.

Top module: `frame_sync_monitor`

## Requirements
- R1: After reset the loss flag `sync_lost` is 1, `pcm_out` is 0, and `pcm_out_valid` is 0. The control word reads 0003h, so mute is enabled, inversion is off and the output pin follows the pin-status register. The pin-status register resets to 0.
- R2: A high run of exactly 16 samples followed by a low run of exactly 240 samples counts as a valid frame. `sync_lost` drops to 0 on the clock edge that samples the first high of the next frame. It stays 0 while valid frames keep arriving.
- R3: A high run that is not exactly 16 samples long sets `sync_lost` to 1. A run that is too short is flagged on the edge that samples the first low. A run that is too long is flagged on the edge that samples the 17th high. A stuck-high line keeps the flag at 1.
- R4: A low run that is not exactly 240 samples long sets `sync_lost` to 1. A run that is too long is flagged on the edge that samples the 241st low. A run that is too short is flagged on the edge that samples the next high.
- R5: Once `sync_lost` is 1, it returns to 0 only at the end of a complete frame that satisfies R2. A frame that contained the fault does not clear it, and the flag only ever clears on an edge that samples a rising sync.
- R6: Control bit 0 is the mute enable. When it is 1, every output sample is 0 from the clock after `sync_lost` rises, and the output stays at 0 until re-lock. While the link is locked, samples pass through.
- R7: When control bit 0 is 0, samples pass through even while `sync_lost` is 1.
- R8: When control bit 2 is 1, each sample is negated, and the most negative code (80000h) maps to 7FFFFh. When bit 2 is 0, samples are unchanged. `pcm_out`/`pcm_out_valid` update one clock after `pcm_in`/`pcm_in_valid`.
- R9: When control bit 1 is 0, `gpo_out` follows `slot_gpo_bit`. When it is 1, `gpo_out` follows the pin-status register bit.
- R10: A write with `wr_addr`=0 loads the control word. A write with `wr_addr`=1 loads only the pin-status bit from `wr_data[0]` and leaves the control word untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; sync and samples are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Frame-sync line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control word, 1 selects the pin-status word |
| wr_data | input | 16 | Register write data |
| slot_gpo_bit | input | 1 | Output-pin bit taken from outgoing link slot 12 |
| pcm_in | input | 20 | Incoming two's complement sample |
| pcm_in_valid | input | 1 | Strobe for `pcm_in` |
| pcm_out | output | 20 | Conditioned sample toward the converter |
| pcm_out_valid | output | 1 | Strobe for `pcm_out` |
| sync_lost | output | 1 | Loss-of-sync flag |
| gpo_out | output | 1 | General-purpose output pin |

## Verification
The bench sends frames whose high run is one clock short or one clock long, frames whose low run is one clock short or long, and a sync line stuck high. For each it checks the exact edge on which the flag rises. A tracker that counted off by one would either miss these faults or flag a good frame. After each fault the bench confirms that the damaged frame does not re-lock the link and that the next clean frame does; a design that cleared the flag on any rising edge would fail that check. Negating the most negative code catches an inverter that wraps to itself instead of saturating. Muted samples are checked both on the first clock after the loss and while it persists.

// File: rtl/fsm_mon_pkg.sv
package fsm_mon_pkg;

    localparam int REG_W        = 16;
    localparam int MUTE_BIT     = 0;
    localparam int GPO_SEL_BIT  = 1;
    localparam int INVERT_BIT   = 2;
    localparam logic [REG_W-1:0] CTRL_RESET = 16'h0003;

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_PIN  = 1'b1
    } reg_addr_e;

endpackage

// File: rtl/sync_cadence_tracker.sv
module sync_cadence_tracker #(
    parameter int HIGH_LEN = 16,
    parameter int LOW_LEN  = 240
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic loss_o
);
    localparam int RUN_W = $clog2(LOW_LEN + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
    localparam logic [RUN_W-1:0] HI_RUN  = RUN_W'(HIGH_LEN);
    localparam logic [RUN_W-1:0] LO_RUN  = RUN_W'(LOW_LEN);

    typedef struct packed {
        logic             lvl;
        logic [RUN_W-1:0] run;
        logic             hi_ok;
        logic             loss;
    } trk_t;

    trk_t st_d, st_q;
    logic viol, good;

    always_comb begin
        st_d = st_q;
        viol = 1'b0;
        good = 1'b0;
        st_d.lvl = sync_in;
        if (sync_in == st_q.lvl) begin
            if (st_q.run != RUN_MAX) st_d.run = st_q.run + 1'b1;
        end else begin
            st_d.run = RUN_W'(1);
        end
        // run continues past its allowed length
        if (sync_in && st_q.lvl && st_q.run == HI_RUN) viol = 1'b1;
        if (!sync_in && !st_q.lvl && st_q.run == LO_RUN) begin
            viol = 1'b1;
            st_d.hi_ok = 1'b0;
        end
        // falling sample closes a high run
        if (!sync_in && st_q.lvl) begin
            st_d.hi_ok = (st_q.run == HI_RUN);
            viol = (st_q.run != HI_RUN);
        end
        // rising sample closes a low run and with it a frame
        if (sync_in && !st_q.lvl) begin
            good = st_q.hi_ok && (st_q.run == LO_RUN);
            viol = !good;
            st_d.hi_ok = 1'b0;
        end
        if (viol)      st_d.loss = 1'b1;
        else if (good) st_d.loss = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{lvl: 1'b0, run: '0, hi_ok: 1'b0, loss: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign loss_o = st_q.loss;

    assert_long_high_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.lvl && sync_in && st_q.run == HI_RUN) |=> loss_o);

    assert_long_low_R4: assert property (@(posedge clk) disable iff (rst)
        (!st_q.lvl && !sync_in && st_q.run == LO_RUN) |=> loss_o);

    assert_clear_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(loss_o) |-> $past(sync_in && !st_q.lvl));

endmodule

// File: rtl/link_ctrl_regs.sv
module link_ctrl_regs
    import fsm_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             slot_gpo_bit,
    output logic             mute_en_o,
    output logic             invert_o,
    output logic             gpo_o
);
    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic             pin;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            if (reg_addr_e'(wr_addr) == ADDR_CTRL) rg_d.ctrl = wr_data;
            else                                   rg_d.pin  = wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rg_q <= '{ctrl: CTRL_RESET, pin: 1'b0};
        else     rg_q <= rg_d;
    end

    assign mute_en_o = rg_q.ctrl[MUTE_BIT];
    assign invert_o  = rg_q.ctrl[INVERT_BIT];
    assign gpo_o     = rg_q.ctrl[GPO_SEL_BIT] ? rg_q.pin : slot_gpo_bit;

    assert_pin_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr) |=> (rg_q.pin == $past(wr_data[0])));

    assert_ctrl_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr) |=> $stable(rg_q.ctrl));

endmodule

// File: rtl/pcm_sample_path.sv
module pcm_sample_path #(
    parameter int SAMPLE_W = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                in_valid,
    input  logic                mute_i,
    input  logic                invert_i,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_valid
);
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

    typedef struct packed {
        logic [SAMPLE_W-1:0] data;
        logic                vld;
    } smp_t;

    smp_t sp_d, sp_q;
    logic [SAMPLE_W-1:0] shaped;

    always_comb begin
        if (!invert_i)                shaped = in_data;
        else if (in_data == MOST_NEG) shaped = MOST_POS;
        else                          shaped = -in_data;

        sp_d     = sp_q;
        sp_d.vld = in_valid;
        if (mute_i)        sp_d.data = '0;
        else if (in_valid) sp_d.data = shaped;
    end

    always_ff @(posedge clk) begin
        if (rst) sp_q <= '{data: '0, vld: 1'b0};
        else     sp_q <= sp_d;
    end

    assign out_data  = sp_q.data;
    assign out_valid = sp_q.vld;

    assert_mute_zero_R6: assert property (@(posedge clk) disable iff (rst)
        mute_i |=> (out_data == '0));

    assert_valid_lag_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    assert_saturate_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && invert_i && !mute_i && in_data == MOST_NEG) |=> (out_data == MOST_POS));

endmodule

// File: rtl/frame_sync_monitor.sv
module frame_sync_monitor
    import fsm_mon_pkg::*;
#(
    parameter int HIGH_LEN = 16,
    parameter int LOW_LEN  = 240,
    parameter int SAMPLE_W = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sync_in,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                slot_gpo_bit,
    input  logic [SAMPLE_W-1:0] pcm_in,
    input  logic                pcm_in_valid,
    output logic [SAMPLE_W-1:0] pcm_out,
    output logic                pcm_out_valid,
    output logic                sync_lost,
    output logic                gpo_out
);
    logic loss_w, mute_en_w, invert_w, mute_now;

    sync_cadence_tracker #(.HIGH_LEN(HIGH_LEN), .LOW_LEN(LOW_LEN)) u_track (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .loss_o  (loss_w)
    );

    link_ctrl_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .slot_gpo_bit (slot_gpo_bit),
        .mute_en_o    (mute_en_w),
        .invert_o     (invert_w),
        .gpo_o        (gpo_out)
    );

    assign mute_now = mute_en_w && loss_w;

    pcm_sample_path #(.SAMPLE_W(SAMPLE_W)) u_path (
        .clk       (clk),
        .rst       (rst),
        .in_data   (pcm_in),
        .in_valid  (pcm_in_valid),
        .mute_i    (mute_now),
        .invert_i  (invert_w),
        .out_data  (pcm_out),
        .out_valid (pcm_out_valid)
    );

    assign sync_lost = loss_w;

    assert_pass_unmuted_R7: assert property (@(posedge clk) disable iff (rst)
        (pcm_in_valid && !mute_en_w && !invert_w) |=> (pcm_out == $past(pcm_in)));

endmodule

// File: tb/frame_sync_monitor_bench.sv
module frame_sync_monitor_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        sync_in;
    logic        wr_en;
    logic        wr_addr;
    logic [15:0] wr_data;
    logic        slot_gpo_bit;
    logic [19:0] pcm_in;
    logic        pcm_in_valid;
    logic [19:0] pcm_out;
    logic        pcm_out_valid;
    logic        sync_lost;
    logic        gpo_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    frame_sync_monitor u_frame_sync_monitor (
        .clk(clk), .rst(rst), .sync_in(sync_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .slot_gpo_bit(slot_gpo_bit), .pcm_in(pcm_in),
        .pcm_in_valid(pcm_in_valid), .pcm_out(pcm_out), .pcm_out_valid(pcm_out_valid),
        .sync_lost(sync_lost), .gpo_out(gpo_out)
    );

    // {control word, input sample, expected output} taken while the link is unlocked
    localparam logic [55:0] VEC [9] = '{
        {16'h0001, 20'h12345, 20'h00000},   // R6 muted
        {16'h0005, 20'h7FFFF, 20'h00000},   // R6 muted with inversion
        {16'h0000, 20'h12345, 20'h12345},   // R7 pass
        {16'h0000, 20'h80000, 20'h80000},   // R7 pass
        {16'h0004, 20'h12345, 20'hEDCBB},   // R8 negate
        {16'h0004, 20'h80000, 20'h7FFFF},   // R8 saturate
        {16'h0004, 20'h7FFFF, 20'h80001},   // R8 negate
        {16'h0004, 20'h00000, 20'h00000},   // R8 zero
        {16'h0004, 20'hFFFFF, 20'h00001}    // R8 minus one
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic s);
        sync_in = s;
        @(negedge clk);
    endtask

    task automatic run(input logic s, input int n);
        for (int i = 0; i < n; i++) cyc(s);
    endtask

    task automatic write_reg(input logic a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_sample(input logic s, input logic [19:0] d);
        pcm_in = d; pcm_in_valid = 1'b1;
        cyc(s);
        pcm_in_valid = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; sync_in = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
        slot_gpo_bit = 1'b1; pcm_in = '0; pcm_in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 loss", 32'(sync_lost), 1);
        chk("R1 pcm_out", 32'(pcm_out), 0);
        chk("R1 valid", 32'(pcm_out_valid), 0);
        chk("R1 gpo from pin reg", 32'(gpo_out), 0);

        for (int k = 0; k < 9; k++) begin
            write_reg(1'b0, VEC[k][55:40]);
            send_sample(1'b0, VEC[k][39:20]);
            chk("R6/R7/R8 table out", 32'(pcm_out), 32'(VEC[k][19:0]));
            chk("R8 valid lag", 32'(pcm_out_valid), 1);
        end
        cyc(1'b0);
        chk("R8 valid drops", 32'(pcm_out_valid), 0);

        // lock: mute on, gpo from slot, no inversion
        write_reg(1'b0, 16'h0001);
        run(1'b1, 16); run(1'b0, 240);
        chk("R2 not yet locked", 32'(sync_lost), 1);
        cyc(1'b1);
        chk("R2 lock", 32'(sync_lost), 0);
        send_sample(1'b1, 20'h00ABC);
        chk("R6 locked passes", 32'(pcm_out), 32'h00ABC);
        run(1'b1, 13);
        chk("R2 still locked", 32'(sync_lost), 0);
        cyc(1'b0);
        chk("R3 short high", 32'(sync_lost), 1);
        send_sample(1'b0, 20'h11111);
        chk("R6 muted first", 32'(pcm_out), 0);
        cyc(1'b0);
        chk("R6 muted held", 32'(pcm_out), 0);
        run(1'b0, 237);
        cyc(1'b1);
        chk("R5 bad frame no relock", 32'(sync_lost), 1);
        run(1'b1, 15); run(1'b0, 240); cyc(1'b1);
        chk("R5 relock", 32'(sync_lost), 0);

        run(1'b1, 15);
        chk("R2 16 highs ok", 32'(sync_lost), 0);
        cyc(1'b1);
        chk("R3 long high", 32'(sync_lost), 1);
        run(1'b1, 100);
        chk("R3 stuck high", 32'(sync_lost), 1);
        run(1'b0, 240); cyc(1'b1);
        chk("R5 no relock after stuck", 32'(sync_lost), 1);
        run(1'b1, 15); run(1'b0, 240); cyc(1'b1);
        chk("R5 relock 2", 32'(sync_lost), 0);

        run(1'b1, 15); run(1'b0, 239);
        chk("R4 before short low ends", 32'(sync_lost), 0);
        cyc(1'b1);
        chk("R4 short low", 32'(sync_lost), 1);
        run(1'b1, 15); run(1'b0, 240); cyc(1'b1);
        chk("R5 relock 3", 32'(sync_lost), 0);

        run(1'b1, 15); run(1'b0, 240);
        chk("R4 240 lows ok", 32'(sync_lost), 0);
        cyc(1'b0);
        chk("R4 long low", 32'(sync_lost), 1);

        write_reg(1'b0, 16'h0000);
        send_sample(1'b0, 20'h2468A);
        chk("R7 pass while lost", 32'(pcm_out), 32'h2468A);
        chk("R7 loss present", 32'(sync_lost), 1);

        slot_gpo_bit = 1'b1; cyc(1'b0);
        chk("R9 gpo slot 1", 32'(gpo_out), 1);
        slot_gpo_bit = 1'b0; cyc(1'b0);
        chk("R9 gpo slot 0", 32'(gpo_out), 0);
        write_reg(1'b1, 16'hFFFF);
        chk("R10 select untouched", 32'(gpo_out), 0);
        send_sample(1'b0, 20'h13579);
        chk("R10 control untouched", 32'(pcm_out), 32'h13579);
        write_reg(1'b0, 16'h0002);
        chk("R9 gpo from pin reg", 32'(gpo_out), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule